// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block keeps a small condition register that is loaded whenever a compare strobe arrives with two 32-bit operands. The register records whether the operands were equal. When they differ, it records separately how they order as signed values and how they order as unsigned values. A branch strobe presents a 4-bit condition selector, a 10-bit signed halfword offset and the address of the branch instruction. The block answers in the same cycle with a taken indication, the address to continue from and an illegal-selector indication.

The flags are state and the branch answer is combinational. A compare in one cycle is therefore visible to a branch in the next cycle. A branch in the same cycle as a compare still sees the older flags. The surrounding pipeline owns the program counter and applies the result.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset the condition register is all zero, so selector 0 (equal) is not taken and selector 1 (not equal) is taken.
- R2: A compare of equal operands leaves only the equality flag set. Selector 0 is then taken, and selectors 2, 3, 4 and 5 (strict orderings) are not taken.
- R3: A compare of unequal operands sets the signed-less or signed-greater flag from a two's-complement comparison. Selector 2 branches on signed-less and selector 3 on signed-greater.
- R4: A compare of unequal operands sets the unsigned-less or unsigned-greater flag from an unsigned comparison, independently of the signed result. Selector 4 branches on unsigned-less and selector 5 on unsigned-greater.
- R5: Selector 1 is taken exactly when the equality flag is clear.
- R6: The or-equal selectors also take the branch on equality: 6 is signed greater-or-equal, 7 signed less-or-equal, 8 unsigned greater-or-equal and 9 unsigned less-or-equal.
- R7: A taken branch targets the instruction address plus the offset sign-extended and doubled (offset 0x1FF gives +1022, 0x200 gives -1024, 0x3FF gives -2), with 32-bit wraparound.
- R8: A branch that is not taken reports the instruction address plus 2 as its target.
- R9: Selectors 10 to 15 assert the illegal indication during the branch strobe, never take the branch, and report the fall-through target.
- R10: The condition register changes only on a clock edge with the compare strobe high. Branch strobes and operand changes without the strobe leave it unchanged.
- R11: Flags loaded at a compare edge are seen by a branch in the following cycle. A branch in the same cycle as a compare sees the previous flags.
- R12: With the branch strobe low, both the taken and the illegal indications are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmpValid | input | 1 | Compare strobe; loads the flags at the clock edge |
| cmpOpA | input | 32 | First compare operand |
| cmpOpB | input | 32 | Second compare operand |
| brValid | input | 1 | Branch strobe |
| brCond | input | 4 | Condition selector, 0 to 9 legal |
| brOffset | input | 10 | Signed halfword displacement |
| brPc | input | 32 | Address of the branch instruction |
| brTaken | output | 1 | Branch condition met (combinational) |
| brTarget | output | 32 | Next address: target if taken, else address plus 2 |
| brIllegal | output | 1 | Selector outside 0 to 9 during a branch strobe |

## Verification
The branch outputs depend on the inputs without a register, so they are due in the same cycle as the branch strobe. The flags take exactly one clock edge after a compare strobe. The bench drives a compare in one low clock phase and lets a single rising edge pass. It then drives the branch in the next low phase and samples the outputs 1 ns later, before the next edge. A directed case puts a compare and a branch in the same cycle and samples before the edge. It samples again after the edge, which separates the old flag values from the new ones.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  // Flag bit positions inside the condition register
  localparam int FLAG_GT  = 0;
  localparam int FLAG_LT  = 1;
  localparam int FLAG_EQ  = 2;
  localparam int FLAG_GTU = 3;
  localparam int FLAG_LTU = 4;
  localparam int FLAG_W   = 5;

  // Branch condition selectors
  typedef enum logic [3:0] {
    COND_EQ  = 4'd0,
    COND_NE  = 4'd1,
    COND_LT  = 4'd2,
    COND_GT  = 4'd3,
    COND_LTU = 4'd4,
    COND_GTU = 4'd5,
    COND_GE  = 4'd6,
    COND_LE  = 4'd7,
    COND_GEU = 4'd8,
    COND_LEU = 4'd9
  } cond_e;

  localparam int COND_LEGAL_MAX = 9;

  // Strobes from control to datapath
  typedef struct packed {
    logic flagLoad;
    logic takeBranch;
  } cbr_strobe_t;

endpackage

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
#(
  parameter int COND_W = 4
) (
  input  logic                cmpValid,
  input  logic                brValid,
  input  logic [COND_W-1:0]   brCond,
  input  logic [FLAG_W-1:0]   flags,
  output cbr_strobe_t         strobes,
  output logic                brTaken,
  output logic                brIllegal
);

  logic condLegal;
  logic condMet;

  assign condLegal = (int'(brCond) <= COND_LEGAL_MAX);

  always_comb begin
    condMet = 1'b0;
    unique case (brCond)
      COND_EQ:  condMet = flags[FLAG_EQ];
      COND_NE:  condMet = !flags[FLAG_EQ];
      COND_LT:  condMet = flags[FLAG_LT];
      COND_GT:  condMet = flags[FLAG_GT];
      COND_LTU: condMet = flags[FLAG_LTU];
      COND_GTU: condMet = flags[FLAG_GTU];
      COND_GE:  condMet = flags[FLAG_GT]  | flags[FLAG_EQ];
      COND_LE:  condMet = flags[FLAG_LT]  | flags[FLAG_EQ];
      COND_GEU: condMet = flags[FLAG_GTU] | flags[FLAG_EQ];
      COND_LEU: condMet = flags[FLAG_LTU] | flags[FLAG_EQ];
      default:  condMet = 1'b0;
    endcase
  end

  assign brTaken            = brValid && condLegal && condMet;
  assign brIllegal          = brValid && !condLegal;
  assign strobes.flagLoad   = cmpValid;
  assign strobes.takeBranch = brTaken;

endmodule

// File: rtl/cbr_datapath.sv
module cbr_datapath
  import cbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  cbr_strobe_t         strobes,
  input  logic [DATA_W-1:0]   cmpOpA,
  input  logic [DATA_W-1:0]   cmpOpB,
  input  logic [OFF_W-1:0]    brOffset,
  input  logic [ADDR_W-1:0]   brPc,
  output logic [FLAG_W-1:0]   flags,
  output logic [ADDR_W-1:0]   brTarget
);

  localparam int EXT_W = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);

  logic [FLAG_W-1:0] flagsQ;
  logic [FLAG_W-1:0] flagsNext;
  logic [ADDR_W-1:0] byteDisp;
  logic              opsEqual;

  assign opsEqual = (cmpOpA == cmpOpB);

  always_comb begin
    flagsNext = '0;
    if (opsEqual) begin
      flagsNext[FLAG_EQ] = 1'b1;
    end else begin
      flagsNext[FLAG_LT]  = $signed(cmpOpA) < $signed(cmpOpB);
      flagsNext[FLAG_GT]  = $signed(cmpOpA) > $signed(cmpOpB);
      flagsNext[FLAG_LTU] = cmpOpA < cmpOpB;
      flagsNext[FLAG_GTU] = cmpOpA > cmpOpB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flagsQ <= '0;
    else if (strobes.flagLoad) flagsQ <= flagsNext;
  end

  assign flags    = flagsQ;
  assign byteDisp = {{EXT_W{brOffset[OFF_W-1]}}, brOffset, 1'b0};
  assign brTarget = strobes.takeBranch ? (brPc + byteDisp) : (brPc + INSN_BYTES);

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10,
  parameter int COND_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmpValid,
  input  logic [DATA_W-1:0] cmpOpA,
  input  logic [DATA_W-1:0] cmpOpB,
  input  logic              brValid,
  input  logic [COND_W-1:0] brCond,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [ADDR_W-1:0] brPc,
  output logic              brTaken,
  output logic [ADDR_W-1:0] brTarget,
  output logic              brIllegal
);

  cbr_strobe_t       strobes;
  logic [FLAG_W-1:0] flagsQ;

  cbr_ctrl #(.COND_W(COND_W)) u_ctrl (
    .cmpValid  (cmpValid),
    .brValid   (brValid),
    .brCond    (brCond),
    .flags     (flagsQ),
    .strobes   (strobes),
    .brTaken   (brTaken),
    .brIllegal (brIllegal)
  );

  cbr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmpOpA   (cmpOpA),
    .cmpOpB   (cmpOpB),
    .brOffset (brOffset),
    .brPc     (brPc),
    .flags    (flagsQ),
    .brTarget (brTarget)
  );

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker
  import cbr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int COND_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmpValid,
  input logic [DATA_W-1:0] cmpOpA,
  input logic [DATA_W-1:0] cmpOpB,
  input logic              brValid,
  input logic [COND_W-1:0] brCond,
  input logic [ADDR_W-1:0] brPc,
  input logic              brTaken,
  input logic [ADDR_W-1:0] brTarget,
  input logic              brIllegal,
  input logic [FLAG_W-1:0] flagsQ
);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !brValid |-> (!brTaken && !brIllegal));

  assert_illegal_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    brValid |-> (brIllegal == (int'(brCond) > COND_LEGAL_MAX)));

  assert_illegal_no_take_R9: assert property (@(posedge clk) disable iff (!rstN)
    brIllegal |-> !brTaken);

  assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rstN)
    !brTaken |-> (brTarget == brPc + ADDR_W'(2)));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid |=> $stable(flagsQ));

  assert_eq_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && (cmpOpA == cmpOpB)) |=> (flagsQ == FLAG_W'(1 << FLAG_EQ)));

  assert_unsigned_gt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && (cmpOpA > cmpOpB)) |=> (flagsQ[FLAG_GTU] && !flagsQ[FLAG_LTU]));

  assert_signed_lt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmpValid && ($signed(cmpOpA) < $signed(cmpOpB))) |=> (flagsQ[FLAG_LT] && !flagsQ[FLAG_GT]));

endmodule

bind cmp_branch_unit cbr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COND_W(COND_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmpValid  (cmpValid),
  .cmpOpA    (cmpOpA),
  .cmpOpB    (cmpOpB),
  .brValid   (brValid),
  .brCond    (brCond),
  .brPc      (brPc),
  .brTaken   (brTaken),
  .brTarget  (brTarget),
  .brIllegal (brIllegal),
  .flagsQ    (flagsQ)
);

// File: tb/cmp_branch_unit_tb.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpValid = 1'b0;
  logic [31:0] cmpOpA = '0;
  logic [31:0] cmpOpB = '0;
  logic        brValid = 1'b0;
  logic [3:0]  brCond = '0;
  logic [9:0]  brOffset = '0;
  logic [31:0] brPc = '0;
  logic        brTaken;
  logic [31:0] brTarget;
  logic        brIllegal;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cmp_branch_unit u_dut (
    .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .cmpOpA(cmpOpA), .cmpOpB(cmpOpB),
    .brValid(brValid), .brCond(brCond), .brOffset(brOffset), .brPc(brPc),
    .brTaken(brTaken), .brTarget(brTarget), .brIllegal(brIllegal)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  cond;
    logic [9:0]  off;
    logic [31:0] pc;
    logic        expTaken;
    logic        expIllegal;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'd5,        32'd5,        4'd0,  10'h010, 32'h0000_1000, 1'b1, 1'b0}, // R2 equal
    '{32'd5,        32'd5,        4'd1,  10'h010, 32'h0000_1000, 1'b0, 1'b0}, // R5
    '{32'd5,        32'd5,        4'd6,  10'h1FF, 32'h0000_2000, 1'b1, 1'b0}, // R6 ge
    '{32'd5,        32'd5,        4'd2,  10'h004, 32'h0000_2000, 1'b0, 1'b0}, // R2 no lt
    '{32'd5,        32'd5,        4'd5,  10'h004, 32'h0000_2000, 1'b0, 1'b0}, // R2 no gtu
    '{32'd5,        32'd5,        4'd8,  10'h200, 32'h0000_3000, 1'b1, 1'b0}, // R6 geu, R7 -1024
    '{32'hFFFF_FFFF, 32'd1,       4'd2,  10'h3FF, 32'h0000_0100, 1'b1, 1'b0}, // R3 signed lt, R7 -2
    '{32'hFFFF_FFFF, 32'd1,       4'd5,  10'h020, 32'h0000_0100, 1'b1, 1'b0}, // R4 unsigned gt
    '{32'hFFFF_FFFF, 32'd1,       4'd4,  10'h020, 32'h0000_0100, 1'b0, 1'b0}, // R4 no ltu
    '{32'hFFFF_FFFF, 32'd1,       4'd3,  10'h020, 32'h0000_0100, 1'b0, 1'b0}, // R3 no gt
    '{32'hFFFF_FFFF, 32'd1,       4'd1,  10'h020, 32'h0000_0100, 1'b1, 1'b0}, // R5 ne
    '{32'd3,        32'd7,        4'd7,  10'h200, 32'h0000_0100, 1'b1, 1'b0}, // R6 le, R7 wrap
    '{32'd3,        32'd7,        4'd8,  10'h008, 32'h0000_0400, 1'b0, 1'b0}, // R6 geu fails
    '{32'd9,        32'd2,        4'd9,  10'h008, 32'h0000_0400, 1'b0, 1'b0}, // R6 leu fails
    '{32'd9,        32'd2,        4'd3,  10'h1FF, 32'h0000_0400, 1'b1, 1'b0}, // R3 gt, R7 +1022
    '{32'd2,        32'd9,        4'd9,  10'h001, 32'h0000_0400, 1'b1, 1'b0}, // R6 leu
    '{32'h8000_0000, 32'h7FFF_FFFF, 4'd2, 10'h010, 32'h0000_0800, 1'b1, 1'b0}, // R3 min < max
    '{32'h8000_0000, 32'h7FFF_FFFF, 4'd5, 10'h010, 32'h0000_0800, 1'b1, 1'b0}, // R4 unsigned gt
    '{32'd7,        32'd7,        4'd10, 10'h010, 32'h0000_0800, 1'b0, 1'b1}, // R9
    '{32'd7,        32'd7,        4'd15, 10'h010, 32'h0000_0800, 1'b0, 1'b1}  // R9
  };

  function automatic logic [31:0] refTarget(input logic [31:0] pc, input logic [9:0] off,
                                            input logic taken);
    logic [31:0] disp;
    disp = 32'($signed(off)) * 32'd2;
    return taken ? pc + disp : pc + 32'd2;
  endfunction

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic checkWord(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCompare(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmpValid = 1'b1; cmpOpA = a; cmpOpB = b;
    @(negedge clk);
    cmpValid = 1'b0;
  endtask

  // Drive a branch in the current low phase and check 1 ns later
  task automatic probe(input string req, input logic [3:0] cond, input logic [9:0] off,
                       input logic [31:0] pc, input logic expT, input logic expI);
    brValid = 1'b1; brCond = cond; brOffset = off; brPc = pc;
    #1;
    checkBit(req, brTaken, expT);
    checkBit(req, brIllegal, expI);
    checkWord(req, brTarget, refTarget(pc, off, expT));
    brValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset flags are zero
    probe("R1 eq after reset", 4'd0, 10'h010, 32'h100, 1'b0, 1'b0);
    probe("R1 ne after reset", 4'd1, 10'h010, 32'h100, 1'b1, 1'b0);
    probe("R1 geu after reset", 4'd8, 10'h010, 32'h100, 1'b0, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      doCompare(VECS[i].a, VECS[i].b);
      probe($sformatf("table vector %0d", i), VECS[i].cond, VECS[i].off, VECS[i].pc,
            VECS[i].expTaken, VECS[i].expIllegal);
    end

    // R12: idle strobe gives quiet outputs even with an illegal selector
    brValid = 1'b0; brCond = 4'd12; #1;
    checkBit("R12 taken idle", brTaken, 1'b0);
    checkBit("R12 illegal idle", brIllegal, 1'b0);

    // R11: same-cycle compare sees old flags; next cycle sees new
    doCompare(32'd4, 32'd4);
    @(negedge clk);
    cmpValid = 1'b1; cmpOpA = 32'd1; cmpOpB = 32'd2;
    probe("R11 same cycle old eq", 4'd0, 10'h002, 32'h200, 1'b1, 1'b0);
    @(negedge clk);
    cmpValid = 1'b0;
    probe("R11 next cycle no eq", 4'd0, 10'h002, 32'h200, 1'b0, 1'b0);
    probe("R11 next cycle lt", 4'd2, 10'h002, 32'h200, 1'b1, 1'b0);

    // R10: operand changes and branch strobes without compare leave flags alone
    cmpOpA = 32'd50; cmpOpB = 32'd50;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      brValid = 1'b1; brCond = 4'd3;
    end
    @(negedge clk);
    brValid = 1'b0;
    probe("R10 lt kept", 4'd2, 10'h006, 32'h300, 1'b1, 1'b0);
    probe("R10 eq still clear", 4'd0, 10'h006, 32'h300, 1'b0, 1'b0);

    // R1: reset mid-run clears flags again
    doCompare(32'd8, 32'd8);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    probe("R1 reset clears eq", 4'd0, 10'h006, 32'h300, 1'b0, 1'b0);
    probe("R1 reset le false", 4'd7, 10'h006, 32'h300, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule